// File: doc/BRIEF.md
# Equalized carrier output multiplexer

This block sits at the output of an OFDM equalizer. Each cycle it is offered, it takes one equalized carrier: the I and Q values, a confidence factor, the 8-bit channel squared amplitude, a carrier-kind tag and a flag that marks the first non-zero carrier of the symbol. It serialises that carrier onto a narrow output bus at twice the carrier rate. The I sample goes out first and the Q sample follows on the next cycle.

A 4-bit sideband carries the confidence value with I and the upper half of the squared amplitude with Q. The lower half of the squared amplitude sits on its own 4-bit output for both cycles. A phase strobe tells the two samples apart. The block also raises several flags:
- a block-start marker on the first continual carrier;
- valid flags for regular data carriers and for signalling carriers;
- frame and superframe markers, taken from a symbol counter that an external sync input aligns.

The counter covers 68 symbols per frame and 4 frames per superframe. A mode input selects between the 2K and 8K rules for the superframe marker. All output fields come from registers and change on the same clock edge.

Top module: `omx_carrier_mux`

## Requirements
- R1: A carrier accepted on edge E appears on `data_o` as its I value after E and as its Q value after E+1. While no carrier is being emitted, every output is zero.
- R2: `strobe_o` is 1 during the I sample and 0 during the Q sample.
- R3: `side_o` carries the confidence value during I and `h2[7:4]` during Q. `h2lo_o` carries `h2[3:0]` during both samples.
- R4: A carrier offered while an I sample is on the outputs is ignored. It produces no output and does not move the symbol counter.
- R5: A carrier with `first_i` set raises `blk_start_o` for both of its samples. On that carrier both valid flags are low, whatever its kind.
- R6: The kind encoding is 0 for a pilot, 1 for data, 2 for a signalling carrier and 3 for a null carrier. `dat_vld_o` is high only for kind 1 and `tps_vld_o` only for kind 2, in both samples. Pilots and nulls leave both flags low.
- R7: An accepted first carrier with `fsync_i` set makes its symbol symbol 0 of frame 0 and locks the counter. Each later accepted first carrier advances the symbol index modulo 68, and the frame index advances modulo 4 on each wrap. `frm_o` is high on every carrier of symbol 0 of each frame once the counter is locked.
- R8: With `mode8k_i`=1, `sf_o` equals `frm_o`. With `mode8k_i`=0, `sf_o` is high only on symbol 0 of frame 0.
- R9: `fsync_i` has no effect on a carrier whose `first_i` is low.
- R10: After reset all outputs are zero, and the frame and superframe markers stay low until the first sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (twice the carrier rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| car_vld_i | input | 1 | Carrier offered this cycle |
| car_i_i | input | DW | Equalized I value |
| car_q_i | input | DW | Equalized Q value |
| cfd_i | input | CW | Confidence factor |
| h2_i | input | 2*CW | Channel squared amplitude |
| kind_i | input | 2 | Carrier kind (0 pilot, 1 data, 2 signalling, 3 null) |
| first_i | input | 1 | First non-zero carrier of the symbol |
| fsync_i | input | 1 | Frame alignment, meaningful only with first_i |
| mode8k_i | input | 1 | 1 = 8K superframe rule, 0 = 2K rule |
| data_o | output | DW | Multiplexed I/Q sample |
| side_o | output | CW | Confidence (I) / squared amplitude high half (Q) |
| h2lo_o | output | CW | Squared amplitude low half |
| strobe_o | output | 1 | 1 during I, 0 during Q |
| blk_start_o | output | 1 | Block-start marker |
| dat_vld_o | output | 1 | Regular data carrier |
| tps_vld_o | output | 1 | Signalling carrier |
| frm_o | output | 1 | First symbol of a frame |
| sf_o | output | 1 | First symbol of a superframe (mode dependent) |

## Verification
The symbol index and frame index are not visible directly. A miscount shows up as `frm_o` or `sf_o` asserting on the wrong symbol, at the latest one frame (68 symbols) after the error. In 2K mode a wrong frame index can take up to a whole superframe to show. The scoreboard therefore runs more than a full superframe after alignment and also drops a first carrier mid-run. A corrupted phase register shows within two cycles: a Q sample repeats, or a carrier spills into the idle pattern.

// File: rtl/omx_pkg.sv
package omx_pkg;
  typedef enum logic [1:0] {
    KIND_PILOT = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_TPS   = 2'd2,
    KIND_NULL  = 2'd3
  } car_kind_e;

  typedef struct packed {
    logic blk;
    logic dv;
    logic tv;
    logic frm;
    logic sf;
  } car_flags_t;
endpackage

// File: rtl/omx_sym_track.sv
module omx_sym_track #(
  parameter int SPF = 68,
  parameter int FPS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic sync_i,
  output logic lock_o,
  output logic sym_zero_o,
  output logic frm_zero_o
);
  localparam int SBW = (SPF > 1) ? $clog2(SPF) : 1;
  localparam int FBW = (FPS > 1) ? $clog2(FPS) : 1;

  logic [SBW-1:0] sym_q, sym_n;
  logic [FBW-1:0] frm_q, frm_n;
  logic           lock_q, lock_n;

  always_comb begin
    sym_n  = sym_q;
    frm_n  = frm_q;
    lock_n = lock_q;
    if (adv_i) begin
      if (sync_i) begin
        sym_n  = '0;
        frm_n  = '0;
        lock_n = 1'b1;
      end else if (lock_q) begin
        if (sym_q == SBW'(SPF - 1)) begin
          sym_n = '0;
          frm_n = (frm_q == FBW'(FPS - 1)) ? '0 : frm_q + FBW'(1);
        end else begin
          sym_n = sym_q + SBW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q  <= '0;
      frm_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      sym_q  <= sym_n;
      frm_q  <= frm_n;
      lock_q <= lock_n;
    end
  end

  // markers follow the carrier being accepted, so use next-state values
  assign lock_o     = lock_n;
  assign sym_zero_o = (sym_n == '0);
  assign frm_zero_o = (frm_n == '0);
endmodule

// File: rtl/omx_flag_gen.sv
module omx_flag_gen
  import omx_pkg::*;
(
  input  car_kind_e  kind_i,
  input  logic       first_i,
  input  logic       lock_i,
  input  logic       sym_zero_i,
  input  logic       frm_zero_i,
  input  logic       mode8k_i,
  output car_flags_t flags_o
);
  logic frm;

  assign frm = lock_i & sym_zero_i;

  always_comb begin
    flags_o.blk = first_i;
    // first carrier is a continual pilot: never valid
    flags_o.dv  = (kind_i == KIND_DATA) & ~first_i;
    flags_o.tv  = (kind_i == KIND_TPS)  & ~first_i;
    flags_o.frm = frm;
    flags_o.sf  = frm & (mode8k_i | frm_zero_i);
  end
endmodule

// File: rtl/omx_slot.sv
module omx_slot
  import omx_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [DW-1:0] car_i_i,
  input  logic [DW-1:0] car_q_i,
  input  logic [CW-1:0] cfd_i,
  input  logic [2*CW-1:0] h2_i,
  input  car_flags_t    flags_i,
  output logic          busy_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] side_o,
  output logic [CW-1:0] h2lo_o,
  output logic          strobe_o,
  output car_flags_t    flags_o
);
  logic          ph_q;
  logic [DW-1:0] q_hold_q;
  logic [CW-1:0] hhi_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= 1'b0;
      q_hold_q   <= '0;
      hhi_hold_q <= '0;
      data_o     <= '0;
      side_o     <= '0;
      h2lo_o     <= '0;
      strobe_o   <= 1'b0;
      flags_o    <= '0;
    end else if (acc_i) begin
      ph_q       <= 1'b1;
      q_hold_q   <= car_q_i;
      hhi_hold_q <= h2_i[2*CW-1:CW];
      data_o     <= car_i_i;
      side_o     <= cfd_i;
      h2lo_o     <= h2_i[CW-1:0];
      strobe_o   <= 1'b1;
      flags_o    <= flags_i;
    end else if (ph_q) begin
      ph_q       <= 1'b0;
      data_o     <= q_hold_q;
      side_o     <= hhi_hold_q;
      strobe_o   <= 1'b0;
    end else begin
      data_o     <= '0;
      side_o     <= '0;
      h2lo_o     <= '0;
      strobe_o   <= 1'b0;
      flags_o    <= '0;
    end
  end

  assign busy_o = ph_q;
endmodule

// File: rtl/omx_carrier_mux.sv
module omx_carrier_mux
  import omx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int CW  = 4,
  parameter int SPF = 68,
  parameter int FPS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          car_vld_i,
  input  logic [DW-1:0] car_i_i,
  input  logic [DW-1:0] car_q_i,
  input  logic [CW-1:0] cfd_i,
  input  logic [2*CW-1:0] h2_i,
  input  logic [1:0]    kind_i,
  input  logic          first_i,
  input  logic          fsync_i,
  input  logic          mode8k_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] side_o,
  output logic [CW-1:0] h2lo_o,
  output logic          strobe_o,
  output logic          blk_start_o,
  output logic          dat_vld_o,
  output logic          tps_vld_o,
  output logic          frm_o,
  output logic          sf_o
);
  logic       busy, acc;
  logic       lock, sym_zero, frm_zero;
  car_flags_t flags_in, flags_out;

  assign acc = car_vld_i & ~busy;

  omx_sym_track #(.SPF(SPF), .FPS(FPS)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (acc & first_i),
    .sync_i     (fsync_i),
    .lock_o     (lock),
    .sym_zero_o (sym_zero),
    .frm_zero_o (frm_zero)
  );

  omx_flag_gen u_flags (
    .kind_i     (car_kind_e'(kind_i)),
    .first_i    (first_i),
    .lock_i     (lock),
    .sym_zero_i (sym_zero),
    .frm_zero_i (frm_zero),
    .mode8k_i   (mode8k_i),
    .flags_o    (flags_in)
  );

  omx_slot #(.DW(DW), .CW(CW)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .car_i_i  (car_i_i),
    .car_q_i  (car_q_i),
    .cfd_i    (cfd_i),
    .h2_i     (h2_i),
    .flags_i  (flags_in),
    .busy_o   (busy),
    .data_o   (data_o),
    .side_o   (side_o),
    .h2lo_o   (h2lo_o),
    .strobe_o (strobe_o),
    .flags_o  (flags_out)
  );

  assign blk_start_o = flags_out.blk;
  assign dat_vld_o   = flags_out.dv;
  assign tps_vld_o   = flags_out.tv;
  assign frm_o       = flags_out.frm;
  assign sf_o        = flags_out.sf;
endmodule

// File: rtl/omx_carrier_mux_chk.sv
module omx_carrier_mux_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          car_vld_i,
  input logic [DW-1:0] data_o,
  input logic [CW-1:0] side_o,
  input logic [CW-1:0] h2lo_o,
  input logic          strobe_o,
  input logic          blk_start_o,
  input logic          dat_vld_o,
  input logic          tps_vld_o,
  input logic          frm_o,
  input logic          sf_o
);
  // R2: an I sample is always followed by a Q sample
  p_i_then_q_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  // R4: offer during I is dropped, so no I sample next
  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_vld_i && strobe_o) |=> !strobe_o);

  p_start_novld_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_o |-> (!dat_vld_o && !tps_vld_o));

  p_start_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_start_o && strobe_o) |=> blk_start_o);

  p_one_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dat_vld_o && tps_vld_o));

  // R3: low half of squared amplitude held across I and Q
  p_lo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> $stable(h2lo_o));

  p_sf_in_frm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_o |-> frm_o);

  // R1: idle cycles drive zeros
  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_o && !$past(strobe_o)) |->
      (data_o == '0 && side_o == '0 && h2lo_o == '0 && !blk_start_o && !frm_o));
endmodule

bind omx_carrier_mux omx_carrier_mux_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/tb_omx_carrier_mux.sv
module tb_omx_carrier_mux;
  localparam int SPF = 68;
  localparam int FPS = 4;

  typedef struct packed {
    logic [7:0] data;
    logic [3:0] side;
    logic [3:0] lo;
    logic       stb;
    logic       blk;
    logic       dv;
    logic       tv;
    logic       frm;
    logic       sf;
  } item_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       car_vld_i = 1'b0;
  logic [7:0] car_i_i = '0, car_q_i = '0;
  logic [3:0] cfd_i = '0;
  logic [7:0] h2_i = '0;
  logic [1:0] kind_i = '0;
  logic       first_i = 1'b0, fsync_i = 1'b0, mode8k_i = 1'b0;
  logic [7:0] data_o;
  logic [3:0] side_o, h2lo_o;
  logic       strobe_o, blk_start_o, dat_vld_o, tps_vld_o, frm_o, sf_o;

  omx_carrier_mux dut (.*);

  always #10 clk_i = ~clk_i;

  int    n_chk = 0, n_bad = 0;
  item_t exp_q[$];
  string tag_q[$];
  bit    mon_on = 0;
  bit    qnext = 0;

  // bench model of the symbol counter
  int m_sym = 0, m_frm = 0;
  bit m_lock = 0;

  function automatic item_t out_now();
    return '{data_o, side_o, h2lo_o, strobe_o, blk_start_o, dat_vld_o,
             tps_vld_o, frm_o, sf_o};
  endfunction

  task automatic check(input string tag, input item_t act, input item_t exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic [7:0] di, input logic [7:0] dq,
                       input logic [3:0] c, input logic [7:0] h,
                       input logic [1:0] k, input bit f, input bit fs,
                       input bit take, input string tag);
    item_t e;
    bit fr;
    @(negedge clk_i);
    car_vld_i = 1'b1; car_i_i = di; car_q_i = dq; cfd_i = c; h2_i = h;
    kind_i = k; first_i = f; fsync_i = fs;
    if (take) begin
      if (f) begin
        if (fs) begin m_sym = 0; m_frm = 0; m_lock = 1; end
        else if (m_lock) begin
          if (m_sym == SPF - 1) begin m_sym = 0; m_frm = (m_frm + 1) % FPS; end
          else m_sym++;
        end
      end
      fr = m_lock && m_sym == 0;
      e.blk = f;
      e.dv  = (k == 2'd1) && !f;
      e.tv  = (k == 2'd2) && !f;
      e.frm = fr;
      e.sf  = fr && (mode8k_i || m_frm == 0);
      e.lo  = h[3:0];
      e.data = di; e.side = c; e.stb = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
      e.data = dq; e.side = h[7:4]; e.stb = 1'b0;
      exp_q.push_back(e); tag_q.push_back(tag);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    car_vld_i = 1'b0; first_i = 1'b0; fsync_i = 1'b0;
  endtask

  task automatic put(input logic [7:0] di, input logic [7:0] dq,
                     input logic [3:0] c, input logic [7:0] h,
                     input logic [1:0] k, input bit f, input bit fs,
                     input string tag);
    offer(di, dq, c, h, k, f, fs, 1'b1, tag);
    idle();
  endtask

  task automatic symbol(input int s, input string tag);
    put(8'(s), 8'(~s), 4'd3, 8'h5A, 2'd0, 1'b1, 1'b0, tag);
    put(8'(s + 1), 8'h11, 4'd9, 8'hC3, 2'd1, 1'b0, 1'b0, tag);
  endtask

  // monitor: pop expected items as samples appear, otherwise expect idle
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (strobe_o || qnext) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R1: unexpected sample act=%h exp=idle", out_now());
        end else begin
          check(tag_q.pop_front(), out_now(), exp_q.pop_front());
        end
        qnext = qnext ? 1'b0 : strobe_o;
      end else begin
        check("R1 idle", out_now(), '0);
      end
    end
  end

  initial begin
    int wd = 0;
    fork
      begin
        repeat (3) @(negedge clk_i);
        check("R10 reset", out_now(), '0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R10 after release", out_now(), '0);
        mon_on = 1;

        // before lock: first carrier tagged data, markers low (R5, R10)
        put(8'hA1, 8'hB2, 4'hC, 8'h7E, 2'd1, 1'b1, 1'b0, "R5/R10");
        // each kind with distinct patterns (R1, R3, R6)
        put(8'h01, 8'hFE, 4'h1, 8'h12, 2'd0, 1'b0, 1'b0, "R6 pilot");
        put(8'h80, 8'h7F, 4'h8, 8'hF0, 2'd1, 1'b0, 1'b0, "R6 data");
        put(8'h55, 8'hAA, 4'h5, 8'h0F, 2'd2, 1'b0, 1'b0, "R6 tps");
        put(8'hFF, 8'h00, 4'hF, 8'h96, 2'd3, 1'b0, 1'b0, "R6 null");
        put(8'h3C, 8'hC3, 4'h2, 8'h4B, 2'd2, 1'b1, 1'b0, "R5 tps-first");
        // back-to-back accepted carriers (R2)
        offer(8'h10, 8'h20, 4'h1, 8'h21, 2'd1, 1'b0, 1'b0, 1'b1, "R2");
        idle();
        offer(8'h30, 8'h40, 4'h3, 8'h43, 2'd2, 1'b0, 1'b0, 1'b1, "R2");
        idle();
        // dropped offer during I (R4)
        offer(8'h66, 8'h77, 4'h6, 8'h67, 2'd1, 1'b0, 1'b0, 1'b1, "R4 kept");
        offer(8'hDE, 8'hAD, 4'hE, 8'hEE, 2'd2, 1'b1, 1'b1, 1'b0, "R4 dropped");
        idle();
        // sync on non-first carrier ignored (R9)
        put(8'h99, 8'h88, 4'h4, 8'h44, 2'd1, 1'b0, 1'b1, "R9");
        put(8'h9A, 8'h89, 4'h4, 8'h45, 2'd0, 1'b1, 1'b0, "R9 still unlocked");
        // lock and run beyond one 2K superframe (R7, R8)
        mode8k_i = 1'b0;
        put(8'h00, 8'h01, 4'h0, 8'h10, 2'd0, 1'b1, 1'b1, "R7 sync");
        put(8'h02, 8'h03, 4'h7, 8'h20, 2'd1, 1'b0, 1'b0, "R7 sym0");
        for (int s = 1; s < SPF * FPS + 3; s++) symbol(s, "R8 2K");
        // dropped first carrier must not advance the counter (R4)
        offer(8'h12, 8'h34, 4'h1, 8'h56, 2'd1, 1'b0, 1'b0, 1'b1, "R4 kept");
        offer(8'hBE, 8'hEF, 4'h2, 8'h78, 2'd0, 1'b1, 1'b0, 1'b0, "R4 drop first");
        idle();
        mode8k_i = 1'b1;
        for (int s = 0; s < SPF * 2 + 2; s++) symbol(s, "R8 8K");
        repeat (6) @(negedge clk_i);
        mon_on = 0;
        n_chk++;
        if (exp_q.size() != 0) begin
          n_bad++;
          $display("FAIL R1: %0d samples missing act=0 exp=%0d",
                   exp_q.size(), exp_q.size());
        end
      end
      begin
        while (wd < 100000) begin @(posedge clk_i); wd++; end
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=%0d cycles exp=completion", wd);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule